// File: doc/BRIEF.md
# SDRAM Bank Timing Enforcer

This block sits between a memory controller's scheduler and its command encoder. Each clock the scheduler offers one candidate command with a bank number. The block answers combinationally whether that command may go out in the current cycle. A command goes out at the clock edge that ends a cycle in which it was offered and allowed. A refused command is simply held by the scheduler and offered again, and it leaves no trace in the block's state.

The block keeps per-bank counters for the row-level timing rules. It also keeps two global counters: one for the spacing between activates to different banks, and one for the quiet period after a mode register write. A single burst tracker follows the read or write burst that is currently running. From it the block derives the write recovery before a precharge and the automatic close of a bank at the end of an auto-precharge burst. The scheduler marks the cycle of a burst's last data word with a one-cycle end indication. All limits are parameters: row timings are given in picoseconds and converted to clocks by rounding up against the clock period, and the remaining limits are given directly in clocks.

Top module: `bankTimingGate`

## Requirements
- R1: Command codes on cmdReq are NOP=0, ACT=1, RD=2, RDA=3 (read with auto precharge), WR=4, WRA=5 (write with auto precharge), PRE=6, PREALL=7, REF=8, MRS=9, BST=10; NOP and the unused codes 11 to 15 are always allowed and have no effect.
- R2: After reset, whether at power-up or mid-run, every bank reads idle on bankOpen (bit n is bank n) and an ACT to any bank is allowed at once.
- R3: RD, RD, WR and WRA to a bank are allowed only while it is open and at least ceil(TRCD_PS/CLK_PS) clocks (3 by default) after its ACT.
- R4: A PRE or PREALL that covers an open bank is refused until ceil(TRAS_PS/CLK_PS) clocks (6) after that bank's ACT.
- R5: An ACT to a bank is refused while it is open, until ceil(TRP_PS/CLK_PS) clocks (3) after its precharge, and until ceil(TRC_PS/CLK_PS) clocks (8) after its previous ACT.
- R6: Two ACT commands, to any banks, are at least ceil(TRRD_PS/CLK_PS) clocks (2) apart.
- R7: A PRE to a bank is refused while a plain write burst to it runs and for TRDL_CK clocks (2) after the cycle in which burstEnd marks its last data word.
- R8: While an auto-precharge burst runs, every RD, RDA, WR, WRA and BST is refused. At the burstEnd of that burst the bank closes, and its next ACT waits TRP clocks for a read, or TRDL_CK plus TRP clocks (5) for a write.
- R9: Column commands may be issued on consecutive clocks, and each new column command ends the burst before it.
- R10: REF and MRS are allowed only when every bank is idle and every bank's precharge time has elapsed.
- R11: After an MRS, only NOP is allowed for TMRD_CK clocks (2).
- R12: PREALL closes every open bank and starts the precharge time on each of them.
- R13: A refused command changes no bank state and starts no timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands go out on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdReq | input | 4 | Candidate command code |
| bankSel | input | 2 | Bank addressed by the candidate command |
| burstEnd | input | 1 | High in the cycle of the running burst's last data word |
| issueOk | output | 1 | The candidate command may go out in this cycle |
| bankOpen | output | 4 | Per-bank row-open status |

## Verification
The bench replays one command stream and checks the allow decision and the bank status in every cycle. The stream reaches each limit exactly on the first legal cycle and also one cycle before it. An off-by-one counter would therefore allow a command one cycle early or hold it one cycle too long. The stream checks that a write burst blocks a precharge until its recovery has elapsed; a design that ignored the running write would close the row before the last word is stored. It also checks that an auto-precharge write charges recovery plus precharge before the next activate, where a design using the read value would re-open the bank two cycles early. Refused activates and precharges are followed straight away by status samples, so a design that updated state on a refused command would show a bank opening or closing that never happened. A reset issued mid-run must clear a pending row-cycle wait.

// File: rtl/bankGatePkg.sv
package bankGatePkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  localparam logic [3:0] CMD_NOP    = 4'd0;
  localparam logic [3:0] CMD_ACT    = 4'd1;
  localparam logic [3:0] CMD_RD     = 4'd2;
  localparam logic [3:0] CMD_RDA    = 4'd3;
  localparam logic [3:0] CMD_WR     = 4'd4;
  localparam logic [3:0] CMD_WRA    = 4'd5;
  localparam logic [3:0] CMD_PRE    = 4'd6;
  localparam logic [3:0] CMD_PREALL = 4'd7;
  localparam logic [3:0] CMD_REF    = 4'd8;
  localparam logic [3:0] CMD_MRS    = 4'd9;
  localparam logic [3:0] CMD_BST    = 4'd10;

  // Per-bank strobes from the decision logic to the bank timers
  typedef struct packed {
    logic [NUM_BANKS-1:0] act;      // open row, start activate timers
    logic [NUM_BANKS-1:0] preShort; // close row, precharge wait
    logic [NUM_BANKS-1:0] preLong;  // close row, write recovery plus precharge wait
    logic [NUM_BANKS-1:0] wrRec;    // start write recovery before precharge
  } bankStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/bankTimers.sv
module bankTimers
  import bankGatePkg::*;
#(
  parameter int TRCD = 3,
  parameter int TRAS = 6,
  parameter int TRC  = 8,
  parameter int TRP  = 3,
  parameter int TRDL = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          strb,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] colReady,
  output logic [NUM_BANKS-1:0] preReady,
  output logic [NUM_BANKS-1:0] idleReady
);

  localparam int CW = $clog2(TRC + TRAS + TRCD + TRP + TRDL + 1);
  localparam logic [CW-1:0] RCD_LD = CW'(TRCD - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(TRAS - 1);
  localparam logic [CW-1:0] RC_LD  = CW'(TRC - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(TRP - 1);
  localparam logic [CW-1:0] DAL_LD = CW'(TRDL + TRP - 1);
  localparam logic [CW-1:0] RDL_LD = CW'(TRDL - 1);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic          openQ;
    logic [CW-1:0] rcdCnt, rasCnt, rcCnt, rpCnt, wrCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ  <= 1'b0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rcCnt  <= '0;
      end else if (strb.act[i]) begin
        openQ  <= 1'b1;
        rcdCnt <= RCD_LD;
        rasCnt <= RAS_LD;
        rcCnt  <= RC_LD;
      end else begin
        if (strb.preShort[i] || strb.preLong[i]) openQ <= 1'b0;
        if (rcdCnt != '0) rcdCnt <= rcdCnt - 1'b1;
        if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;
        if (rcCnt != '0)  rcCnt  <= rcCnt - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rpCnt <= '0;
        wrCnt <= '0;
      end else begin
        if (strb.preLong[i])       rpCnt <= DAL_LD;
        else if (strb.preShort[i]) rpCnt <= RP_LD;
        else if (rpCnt != '0)      rpCnt <= rpCnt - 1'b1;

        if (strb.wrRec[i])         wrCnt <= RDL_LD;
        else if (wrCnt != '0)      wrCnt <= wrCnt - 1'b1;
      end
    end

    assign bankOpen[i]  = openQ;
    assign actReady[i]  = !openQ && (rpCnt == '0) && (rcCnt == '0);
    assign colReady[i]  = openQ && (rcdCnt == '0);
    assign preReady[i]  = (rasCnt == '0) && (wrCnt == '0);
    assign idleReady[i] = !openQ && (rpCnt == '0);

    // R3
    open_after_act_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.act[i] |=> bankOpen[i]);

    if (TRAS > 1) begin : g_rasChk
      // R4
      ras_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.act[i] |=> !preReady[i]);
    end

    if (TRP > 1) begin : g_rpChk
      // R5
      rp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(bankOpen[i]) |-> !actReady[i]);
    end
  end

endmodule

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankGatePkg::*;
#(
  parameter int TRRD = 2,
  parameter int TMRD = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           cmdReq,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic                 burstEnd,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] actReady,
  input  logic [NUM_BANKS-1:0] colReady,
  input  logic [NUM_BANKS-1:0] preReady,
  input  logic [NUM_BANKS-1:0] idleReady,
  output logic                 issueOk,
  output bankStrobe_t          strb
);

  localparam int GW = $clog2(TRRD + TMRD + 2);
  localparam logic [GW-1:0] RRD_LD = GW'(TRRD - 1);
  localparam logic [GW-1:0] MRD_LD = GW'(TMRD - 1);

  logic [GW-1:0]        rrdCnt, mrsCnt;
  logic                 bActive, bWrite, bAuto;
  logic [BANK_W-1:0]    bBank;
  logic [NUM_BANKS-1:0] selMask, burstMask, preOkVec;
  logic                 isCol, isWrite, isAuto, apBusy, issue, endEv;

  assign selMask   = NUM_BANKS'(1) << bankSel;
  assign burstMask = NUM_BANKS'(1) << bBank;
  assign isWrite   = (cmdReq == CMD_WR) || (cmdReq == CMD_WRA);
  assign isAuto    = (cmdReq == CMD_RDA) || (cmdReq == CMD_WRA);
  assign isCol     = isWrite || (cmdReq == CMD_RD) || (cmdReq == CMD_RDA);
  assign apBusy    = bActive && bAuto;

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      preOkVec[i] = !bankOpen[i] ||
                    (preReady[i] && !(bActive && (bBank == BANK_W'(i)) && (bWrite || bAuto)));
    end
  end

  always_comb begin
    case (cmdReq)
      CMD_ACT:               issueOk = actReady[bankSel] && (rrdCnt == '0);
      CMD_RD, CMD_RDA,
      CMD_WR, CMD_WRA:       issueOk = colReady[bankSel] && !apBusy;
      CMD_PRE:               issueOk = preOkVec[bankSel];
      CMD_PREALL:            issueOk = &preOkVec;
      CMD_REF, CMD_MRS:      issueOk = &idleReady;
      CMD_BST:               issueOk = !apBusy;
      default:               issueOk = 1'b1;
    endcase
    if ((mrsCnt != '0) && (cmdReq != CMD_NOP)) issueOk = 1'b0;
  end

  assign issue = issueOk && (cmdReq != CMD_NOP);
  assign endEv = bActive && (burstEnd ||
                 (issue && (isCol || (cmdReq == CMD_BST) || (cmdReq == CMD_PREALL) ||
                            ((cmdReq == CMD_PRE) && (bankSel == bBank)))));

  always_comb begin
    strb          = '0;
    strb.act      = (issue && (cmdReq == CMD_ACT)) ? selMask : '0;
    strb.preShort = (issue && (cmdReq == CMD_PRE))    ? (selMask & bankOpen) :
                    (issue && (cmdReq == CMD_PREALL)) ? bankOpen : '0;
    if (endEv && bAuto && !bWrite) strb.preShort = strb.preShort | burstMask;
    strb.preLong  = (endEv && bAuto && bWrite)  ? burstMask : '0;
    strb.wrRec    = (endEv && !bAuto && bWrite) ? burstMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bActive <= 1'b0;
      bWrite  <= 1'b0;
      bAuto   <= 1'b0;
      bBank   <= '0;
      rrdCnt  <= '0;
      mrsCnt  <= '0;
    end else begin
      if (issue && isCol) begin
        bActive <= 1'b1;
        bWrite  <= isWrite;
        bAuto   <= isAuto;
        bBank   <= bankSel;
      end else if (endEv) begin
        bActive <= 1'b0;
      end

      if (issue && (cmdReq == CMD_ACT)) rrdCnt <= RRD_LD;
      else if (rrdCnt != '0)            rrdCnt <= rrdCnt - 1'b1;

      if (issue && (cmdReq == CMD_MRS)) mrsCnt <= MRD_LD;
      else if (mrsCnt != '0)            mrsCnt <= mrsCnt - 1'b1;
    end
  end

  // R10
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issue && ((cmdReq == CMD_REF) || (cmdReq == CMD_MRS))) |-> (bankOpen == '0));

  // R8
  ap_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issue && isAuto) |=> !(issueOk && isCol));

  if (TRRD > 1) begin : g_rrdChk
    // R6
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (issue && (cmdReq == CMD_ACT)) |=> !(issueOk && (cmdReq == CMD_ACT)));
  end

  if (TMRD > 1) begin : g_mrdChk
    // R11
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (issue && (cmdReq == CMD_MRS)) |=> !(issueOk && (cmdReq != CMD_NOP)));
  end

endmodule

// File: rtl/bankTimingGate.sv
module bankTimingGate
  import bankGatePkg::*;
#(
  parameter int CLK_PS  = 8000,
  parameter int TRCD_PS = 18000,
  parameter int TRAS_PS = 42000,
  parameter int TRC_PS  = 60000,
  parameter int TRP_PS  = 18000,
  parameter int TRRD_PS = 12000,
  parameter int TRDL_CK = 2,
  parameter int TMRD_CK = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           cmdReq,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic                 burstEnd,
  output logic                 issueOk,
  output logic [NUM_BANKS-1:0] bankOpen
);

  localparam int TRCD = ceilDiv(TRCD_PS, CLK_PS);
  localparam int TRAS = ceilDiv(TRAS_PS, CLK_PS);
  localparam int TRC  = ceilDiv(TRC_PS, CLK_PS);
  localparam int TRP  = ceilDiv(TRP_PS, CLK_PS);
  localparam int TRRD = ceilDiv(TRRD_PS, CLK_PS);

  bankStrobe_t          strb;
  logic [NUM_BANKS-1:0] actReady, colReady, preReady, idleReady;

  bankCtrl #(.TRRD(TRRD), .TMRD(TMRD_CK)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .bankSel(bankSel), .burstEnd(burstEnd),
    .bankOpen(bankOpen), .actReady(actReady), .colReady(colReady), .preReady(preReady),
    .idleReady(idleReady), .issueOk(issueOk), .strb(strb)
  );

  bankTimers #(.TRCD(TRCD), .TRAS(TRAS), .TRC(TRC), .TRP(TRP), .TRDL(TRDL_CK)) i_timers (
    .clk(clk), .rstN(rstN), .strb(strb), .bankOpen(bankOpen), .actReady(actReady),
    .colReady(colReady), .preReady(preReady), .idleReady(idleReady)
  );

endmodule

// File: tb/test_bankTimingGate.sv
module test_bankTimingGate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cmdReq = 4'd0;
  logic [1:0] bankSel = 2'd0;
  logic       burstEnd = 1'b0;
  logic       issueOk;
  logic [3:0] bankOpen;

  int passCnt = 0;
  int totalCnt = 0;

  always #4 clk = ~clk;

  bankTimingGate i_bankTimingGate (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .bankSel(bankSel),
    .burstEnd(burstEnd), .issueOk(issueOk), .bankOpen(bankOpen)
  );

  // fields: req[15:12] cmd[11:8] bank[7:6] burstEnd[5] expOk[4] expOpen[3:0]
  localparam int NV = 45;
  localparam logic [15:0] VEC [NV] = '{
    {4'd10, 4'd9,  2'd0, 1'b0, 1'b1, 4'b0000}, // c0  R10 MRS with all idle
    {4'd11, 4'd1,  2'd0, 1'b0, 1'b0, 4'b0000}, // c1  R11 quiet after MRS
    {4'd11, 4'd1,  2'd0, 1'b0, 1'b1, 4'b0000}, // c2  R11 R13 nothing opened by refusal
    {4'd6,  4'd1,  2'd1, 1'b0, 1'b0, 4'b0001}, // c3  R6
    {4'd6,  4'd1,  2'd1, 1'b0, 1'b1, 4'b0001}, // c4  R6 R13
    {4'd3,  4'd2,  2'd0, 1'b0, 1'b1, 4'b0011}, // c5  R3
    {4'd3,  4'd2,  2'd1, 1'b0, 1'b0, 4'b0011}, // c6  R3
    {4'd3,  4'd2,  2'd1, 1'b0, 1'b1, 4'b0011}, // c7  R3
    {4'd9,  4'd2,  2'd1, 1'b0, 1'b1, 4'b0011}, // c8  R9
    {4'd9,  4'd4,  2'd0, 1'b0, 1'b1, 4'b0011}, // c9  R9
    {4'd7,  4'd6,  2'd0, 1'b1, 1'b0, 4'b0011}, // c10 R7 write running
    {4'd7,  4'd6,  2'd0, 1'b0, 1'b0, 4'b0011}, // c11 R7 recovery
    {4'd7,  4'd6,  2'd0, 1'b0, 1'b1, 4'b0011}, // c12 R7
    {4'd5,  4'd1,  2'd0, 1'b0, 1'b0, 4'b0010}, // c13 R5
    {4'd5,  4'd1,  2'd0, 1'b0, 1'b0, 4'b0010}, // c14 R5
    {4'd5,  4'd1,  2'd0, 1'b0, 1'b1, 4'b0010}, // c15 R5
    {4'd8,  4'd3,  2'd1, 1'b0, 1'b1, 4'b0011}, // c16 R8 read with auto precharge
    {4'd8,  4'd10, 2'd0, 1'b0, 1'b0, 4'b0011}, // c17 R8 BST refused
    {4'd8,  4'd2,  2'd0, 1'b1, 1'b0, 4'b0011}, // c18 R8 other bank refused
    {4'd8,  4'd2,  2'd0, 1'b0, 1'b1, 4'b0001}, // c19 R8 bank 1 closed
    {4'd8,  4'd1,  2'd1, 1'b0, 1'b0, 4'b0001}, // c20 R8
    {4'd8,  4'd1,  2'd1, 1'b0, 1'b1, 4'b0001}, // c21 R8
    {4'd10, 4'd8,  2'd0, 1'b0, 1'b0, 4'b0011}, // c22 R10
    {4'd10, 4'd9,  2'd0, 1'b0, 1'b0, 4'b0011}, // c23 R10
    {4'd4,  4'd7,  2'd0, 1'b0, 1'b0, 4'b0011}, // c24 R4 bank 1 too young
    {4'd1,  4'd0,  2'd0, 1'b0, 1'b1, 4'b0011}, // c25 R1
    {4'd1,  4'd0,  2'd0, 1'b0, 1'b1, 4'b0011}, // c26 R1
    {4'd12, 4'd7,  2'd0, 1'b0, 1'b1, 4'b0011}, // c27 R12
    {4'd12, 4'd8,  2'd0, 1'b0, 1'b0, 4'b0000}, // c28 R12
    {4'd12, 4'd8,  2'd0, 1'b0, 1'b0, 4'b0000}, // c29 R12
    {4'd10, 4'd8,  2'd0, 1'b0, 1'b1, 4'b0000}, // c30 R10
    {4'd6,  4'd1,  2'd2, 1'b0, 1'b1, 4'b0000}, // c31 R6
    {4'd6,  4'd1,  2'd3, 1'b0, 1'b0, 4'b0100}, // c32 R6
    {4'd6,  4'd1,  2'd3, 1'b0, 1'b1, 4'b0100}, // c33 R6
    {4'd8,  4'd5,  2'd2, 1'b0, 1'b1, 4'b1100}, // c34 R8 write with auto precharge
    {4'd8,  4'd4,  2'd3, 1'b1, 1'b0, 4'b1100}, // c35 R8
    {4'd8,  4'd4,  2'd3, 1'b0, 1'b1, 4'b1000}, // c36 R8
    {4'd1,  4'd12, 2'd0, 1'b0, 1'b1, 4'b1000}, // c37 R1 unused code
    {4'd8,  4'd1,  2'd2, 1'b0, 1'b0, 4'b1000}, // c38 R8 recovery plus precharge
    {4'd8,  4'd1,  2'd2, 1'b0, 1'b0, 4'b1000}, // c39 R8
    {4'd8,  4'd1,  2'd2, 1'b0, 1'b1, 4'b1000}, // c40 R8
    {4'd7,  4'd0,  2'd0, 1'b1, 1'b1, 4'b1100}, // c41 R7 last write word
    {4'd7,  4'd6,  2'd3, 1'b0, 1'b0, 4'b1100}, // c42 R7
    {4'd7,  4'd6,  2'd3, 1'b0, 1'b1, 4'b1100}, // c43 R7
    {4'd13, 4'd0,  2'd0, 1'b0, 1'b1, 4'b0100}  // c44 R13
  };

  task automatic checkVal(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    totalCnt++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R2 state after power-up reset
    checkVal(2, "bankOpen after reset", bankOpen, 4'b0000);
    checkVal(1, "NOP allowed", {3'b0, issueOk}, 4'd1);

    for (int c = 0; c < NV; c++) begin
      @(negedge clk);
      cmdReq   = VEC[c][11:8];
      bankSel  = VEC[c][7:6];
      burstEnd = VEC[c][5];
      #1;
      checkVal(int'(VEC[c][15:12]), $sformatf("cycle %0d issueOk", c), {3'b0, issueOk}, {3'b0, VEC[c][4]});
      checkVal(int'(VEC[c][15:12]), $sformatf("cycle %0d bankOpen", c), bankOpen, VEC[c][3:0]);
    end

    // R2 mid-run reset clears open rows and the pending row-cycle wait of bank 2
    @(negedge clk);
    cmdReq = 4'd0; burstEnd = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    cmdReq = 4'd1; bankSel = 2'd2;
    #1;
    checkVal(2, "bankOpen after mid-run reset", bankOpen, 4'b0000);
    checkVal(2, "ACT bank 2 after mid-run reset", {3'b0, issueOk}, 4'd1);

    @(negedge clk);
    cmdReq = 4'd0;
    #1;
    checkVal(2, "bankOpen after ACT", bankOpen, 4'b0100);

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule